// File: doc/BRIEF.md
# Subroutine Link and Return-Address Stack Unit

This unit performs the control-flow operations that move a return address between the program counter and a memory-resident stack. The stack pointer is an ordinary general register. The requesting pipeline stage supplies the following per request: a 3-bit operation code, the current PC, the value of the target register (A), the value of the second register (B) and a signed 16-bit offset.

For each request the unit makes at most one word-wide read or write on its memory port. It then reports three things together for one cycle: the next PC, the updated pointer value to be written back, and a completion strobe. The register file and the memory are outside the block.

The stack grows toward higher addresses. Writes store at the pointer and then advance it. Reads load from the pointer as it stands and then pull it back. A push followed by a pop with the returned pointer therefore does not land on the same word; the caller must account for this asymmetry.

Both the request port and the memory port are valid/ready:
- **Request port.** `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Inputs offered while the unit is busy are ignored.
- **Memory port.** `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay constant until the memory raises `mem_ready`. Read data is taken in the same cycle as `mem_ready`.

Top module: `pcstack_unit`

## Requirements
- R1: Reset, synchronous and active high, returns the unit to idle from any state with `req_ready`=1, `done`=0 and `mem_valid`=0, and drops any operation in flight without a memory transfer.
- R2: Code 0 (register jump) makes no memory request and returns next PC = A and pointer = A.
- R3: Code 1 (link branch) writes the PC to address B, returns next PC = A and pointer = B unchanged.
- R4: Code 2 (register call) writes the PC to address B, returns next PC = A and pointer = B + register bytes.
- R5: Codes 3 (return) and 5 (pop PC) read the word at address A, return it as next PC and return pointer = A − register bytes.
- R6: Code 4 (push PC) writes the PC to address A, returns next PC = PC and pointer = A + register bytes.
- R7: Code 6 (relative call) writes the PC to address A, returns pointer = A + register bytes and next PC = PC + the offset sign-extended from 16 bits; all pointer and PC arithmetic wraps modulo 2^XLEN.
- R8: While a memory request waits for `mem_ready`, its valid, direction, address and write data stay unchanged, `req_ready` is low, and a request offered while busy is not taken.
- R9: `done` is a single-cycle pulse. It comes one cycle after acceptance for operations without a memory access, and one cycle after the memory handshake otherwise. `pc_next` and `ptr_next` are valid with it.
- R10: The register size in bytes is XLEN/8 (4 for XLEN=32, 8 for XLEN=64), and every pointer step uses exactly that amount.
- R11: Code 7 is reserved. It makes no memory request and returns next PC = PC and pointer = A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_pc | input | XLEN | Current program counter |
| req_reg_a | input | XLEN | Value of register A |
| req_reg_b | input | XLEN | Value of register B |
| req_imm | input | IMM_W | Signed PC offset |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts / returns data this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | XLEN | Word to store (the PC) |
| mem_rdata | input | XLEN | Word loaded, valid with mem_ready on reads |
| done | output | 1 | One-cycle completion strobe |
| pc_next | output | XLEN | Next program counter |
| ptr_next | output | XLEN | Updated pointer register value |

## Verification
The bench builds two instances, one with XLEN=32 and one with XLEN=64. The 32-bit instance runs all eight operation codes against a word memory model whose ready can be delayed by a chosen number of cycles. This reaches the stall path, pointer wrap at the top and bottom of the address space, and negative and most-negative offsets. The 64-bit instance exposes the 8-byte pointer step and full-width return addresses that the narrow build cannot show.

// File: rtl/pcstack_pkg.sv
package pcstack_pkg;

  typedef enum logic [2:0] {
    OP_JMP_REG  = 3'd0,
    OP_LINK     = 3'd1,
    OP_CALL_REG = 3'd2,
    OP_RETURN   = 3'd3,
    OP_PUSH_PC  = 3'd4,
    OP_POP_PC   = 3'd5,
    OP_CALL_REL = 3'd6,
    OP_RSVD     = 3'd7
  } pcs_op_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    PCS_REG_A = 2'd0,
    PCS_HOLD  = 2'd1,
    PCS_REL   = 2'd2,
    PCS_LOAD  = 2'd3
  } pcsrc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  typedef struct packed {
    logic   mem_access;
    logic   mem_write;
    logic   base_b;
    step_e  step;
    pcsrc_e pc_src;
  } ctl_t;

endpackage

// File: rtl/pcstack_decode.sv
module pcstack_decode
  import pcstack_pkg::*;
(
  input  logic [2:0] op,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{mem_access: 1'b0, mem_write: 1'b0, base_b: 1'b0,
            step: STEP_NONE, pc_src: PCS_HOLD};
    case (pcs_op_e'(op))
      OP_JMP_REG: begin
        ctl.pc_src = PCS_REG_A;
      end
      OP_LINK: begin
        ctl.mem_access = 1'b1;
        ctl.mem_write  = 1'b1;
        ctl.base_b     = 1'b1;
        ctl.pc_src     = PCS_REG_A;
      end
      OP_CALL_REG: begin
        ctl.mem_access = 1'b1;
        ctl.mem_write  = 1'b1;
        ctl.base_b     = 1'b1;
        ctl.step       = STEP_UP;
        ctl.pc_src     = PCS_REG_A;
      end
      OP_RETURN, OP_POP_PC: begin
        ctl.mem_access = 1'b1;
        ctl.step       = STEP_DOWN;
        ctl.pc_src     = PCS_LOAD;
      end
      OP_PUSH_PC: begin
        ctl.mem_access = 1'b1;
        ctl.mem_write  = 1'b1;
        ctl.step       = STEP_UP;
        ctl.pc_src     = PCS_HOLD;
      end
      OP_CALL_REL: begin
        ctl.mem_access = 1'b1;
        ctl.mem_write  = 1'b1;
        ctl.step       = STEP_UP;
        ctl.pc_src     = PCS_REL;
      end
      default: begin
        ctl.pc_src = PCS_HOLD;
      end
    endcase
  end

endmodule

// File: rtl/pcstack_ptr_step.sv
module pcstack_ptr_step
  import pcstack_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_BYTES = XLEN / 8
) (
  input  logic [XLEN-1:0] base,
  input  step_e           step,
  output logic [XLEN-1:0] result
);

  localparam logic [XLEN-1:0] STEP_AMT = XLEN'(REG_BYTES);

  always_comb begin
    case (step)
      STEP_UP:   result = base + STEP_AMT;
      STEP_DOWN: result = base - STEP_AMT;
      default:   result = base;
    endcase
  end

endmodule

// File: rtl/pcstack_target.sv
module pcstack_target
  import pcstack_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  reg_a,
  input  logic [IMM_W-1:0] imm,
  input  pcsrc_e           src,
  output logic [XLEN-1:0]  pc_new
);

  logic [XLEN-1:0] imm_ext;

  generate
    if (IMM_W < XLEN) begin : g_extend
      assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    case (src)
      PCS_REG_A: pc_new = reg_a;
      PCS_REL:   pc_new = pc + imm_ext;
      default:   pc_new = pc;
    endcase
  end

endmodule

// File: rtl/pcstack_seq.sv
module pcstack_seq
  import pcstack_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            acc_mem,
  input  logic            acc_write,
  input  logic            acc_load,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [XLEN-1:0] acc_wdata,
  input  logic [XLEN-1:0] acc_ptr,
  input  logic [XLEN-1:0] acc_pc,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] ptr_out
);

  state_e          state_q;
  logic            load_q;
  logic            we_q;
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] wdata_q;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] ptr_q;
  logic            take;

  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign mem_valid = (state_q == ST_MEM);
  assign done      = (state_q == ST_DONE);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign pc_out    = pc_q;
  assign ptr_out   = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (take) state_q <= acc_mem ? ST_MEM : ST_DONE;
        ST_MEM:  if (mem_ready) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      pc_q    <= '0;
      ptr_q   <= '0;
    end else if (take) begin
      load_q  <= acc_load;
      we_q    <= acc_write;
      addr_q  <= acc_addr;
      wdata_q <= acc_wdata;
      pc_q    <= acc_pc;
      ptr_q   <= acc_ptr;
    end else if (mem_valid && mem_ready && load_q) begin
      pc_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/pcstack_unit.sv
module pcstack_unit
  import pcstack_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [XLEN-1:0]  req_pc,
  input  logic [XLEN-1:0]  req_reg_a,
  input  logic [XLEN-1:0]  req_reg_b,
  input  logic [IMM_W-1:0] req_imm,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             done,
  output logic [XLEN-1:0]  pc_next,
  output logic [XLEN-1:0]  ptr_next
);

  localparam int REG_BYTES = XLEN / 8;

  ctl_t            ctl;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] ptr_calc;
  logic [XLEN-1:0] pc_calc;

  pcstack_decode u_decode (
    .op  (req_op),
    .ctl (ctl)
  );

  assign base = ctl.base_b ? req_reg_b : req_reg_a;

  pcstack_ptr_step #(.XLEN(XLEN), .REG_BYTES(REG_BYTES)) u_step (
    .base   (base),
    .step   (ctl.step),
    .result (ptr_calc)
  );

  pcstack_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
    .pc     (req_pc),
    .reg_a  (req_reg_a),
    .imm    (req_imm),
    .src    (ctl.pc_src),
    .pc_new (pc_calc)
  );

  pcstack_seq #(.XLEN(XLEN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .acc_mem   (ctl.mem_access),
    .acc_write (ctl.mem_write),
    .acc_load  (ctl.pc_src == PCS_LOAD),
    .acc_addr  (base),
    .acc_wdata (req_pc),
    .acc_ptr   (ptr_calc),
    .acc_pc    (pc_calc),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .done      (done),
    .pc_out    (pc_next),
    .ptr_out   (ptr_next)
  );

endmodule

// File: rtl/pcstack_chk.sv
module pcstack_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic [XLEN-1:0] mem_rdata,
  input logic            done,
  input logic [XLEN-1:0] pc_next
);

  // R1: one clock of reset leaves the unit idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (req_ready && !done && !mem_valid));

  // R8: a stalled memory request holds all its fields
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R8: no new request is taken while memory is pending
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  // R2 / R11: codes without memory complete the next cycle
  a_r2_no_mem_path: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_op == 3'd0 || req_op == 3'd7)) |=>
      (done && !mem_valid));

  // R5: a completed read delivers the loaded word as next PC
  a_r5_load_to_pc: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_we) |=> (done && pc_next == $past(mem_rdata)));

  // R9: done lasts exactly one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind pcstack_unit pcstack_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .done      (done),
  .pc_next   (pc_next)
);

// File: tb/tb_pcstack_unit.sv
module tb_pcstack_unit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- 32-bit instance ----------------
  logic        r_valid = 1'b0;
  logic        r_ready;
  logic [2:0]  r_op = '0;
  logic [31:0] r_pc = '0, r_a = '0, r_b = '0;
  logic [15:0] r_imm = '0;
  logic        m_valid, m_we;
  logic        m_ready = 1'b0;
  logic [31:0] m_addr, m_wdata;
  logic [31:0] m_rdata = '0;
  logic        d_done;
  logic [31:0] d_pc, d_ptr;

  pcstack_unit #(.XLEN(32), .IMM_W(16)) dut (
    .clk(clk), .rst(rst), .req_valid(r_valid), .req_ready(r_ready), .req_op(r_op),
    .req_pc(r_pc), .req_reg_a(r_a), .req_reg_b(r_b), .req_imm(r_imm),
    .mem_valid(m_valid), .mem_ready(m_ready), .mem_we(m_we), .mem_addr(m_addr),
    .mem_wdata(m_wdata), .mem_rdata(m_rdata), .done(d_done), .pc_next(d_pc), .ptr_next(d_ptr)
  );

  // word memory model with programmable ready delay
  logic [31:0] mem [64];
  int          cur_stall = 0;
  int          wcnt = 0;
  int          acc_cnt = 0;
  logic        last_we = 1'b0;
  logic [31:0] last_addr = '0, last_wdata = '0;

  initial for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | i;

  always @(negedge clk) begin
    if (!m_valid) begin
      m_ready = 1'b0;
      wcnt    = 0;
    end else if (!m_ready) begin
      if (wcnt >= cur_stall) begin
        m_ready    = 1'b1;
        acc_cnt++;
        last_we    = m_we;
        last_addr  = m_addr;
        last_wdata = m_wdata;
        m_rdata    = mem[m_addr[7:2]];
        if (m_we) mem[m_addr[7:2]] = m_wdata;
      end else begin
        wcnt++;
      end
    end
  end

  // ---------------- 64-bit instance ----------------
  logic        w_valid = 1'b0;
  logic        w_ready;
  logic [2:0]  w_op = '0;
  logic [63:0] w_pc = '0, w_a = '0, w_b = '0;
  logic [15:0] w_imm = '0;
  logic        wm_valid, wm_we;
  logic        wm_ready = 1'b1;
  logic [63:0] wm_addr, wm_wdata;
  logic [63:0] wm_rdata = 64'h1234_5678_9ABC_DEF0;
  logic        w_done;
  logic [63:0] w_pcn, w_ptr;
  int          w_cnt = 0;
  logic        w_lwe = 1'b0;
  logic [63:0] w_laddr = '0, w_ldata = '0;

  pcstack_unit #(.XLEN(64), .IMM_W(16)) dut_wide (
    .clk(clk), .rst(rst), .req_valid(w_valid), .req_ready(w_ready), .req_op(w_op),
    .req_pc(w_pc), .req_reg_a(w_a), .req_reg_b(w_b), .req_imm(w_imm),
    .mem_valid(wm_valid), .mem_ready(wm_ready), .mem_we(wm_we), .mem_addr(wm_addr),
    .mem_wdata(wm_wdata), .mem_rdata(wm_rdata), .done(w_done), .pc_next(w_pcn), .ptr_next(w_ptr)
  );

  always @(negedge clk) begin
    if (wm_valid) begin
      w_cnt++;
      w_lwe   = wm_we;
      w_laddr = wm_addr;
      w_ldata = wm_wdata;
    end
  end

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [3:0]  stall;
    logic [1:0]  kind;   // 0 none, 1 write, 2 read
    logic [31:0] addr;
    logic [31:0] epc;
    logic [31:0] eptr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_0100, 32'h0000_2000, 32'h0,         16'h0,    4'd0, 2'd0, 32'h0,         32'h0000_2000, 32'h0000_2000},
    '{3'd1, 32'h0000_0104, 32'h0000_3000, 32'h40,        16'h0,    4'd0, 2'd1, 32'h40,        32'h0000_3000, 32'h40},
    '{3'd2, 32'h0000_0208, 32'h0000_4000, 32'h50,        16'h0,    4'd2, 2'd1, 32'h50,        32'h0000_4000, 32'h54},
    '{3'd4, 32'h0000_030C, 32'h60,        32'h999,       16'h0,    4'd1, 2'd1, 32'h60,        32'h0000_030C, 32'h64},
    '{3'd5, 32'h0000_0400, 32'h60,        32'h0,         16'h0,    4'd0, 2'd2, 32'h60,        32'h0000_030C, 32'h5C},
    '{3'd3, 32'h0000_0404, 32'h50,        32'h0,         16'h0,    4'd3, 2'd2, 32'h50,        32'h0000_0208, 32'h4C},
    '{3'd6, 32'h0000_1000, 32'h80,        32'h0,         16'h0010, 4'd0, 2'd1, 32'h80,        32'h0000_1010, 32'h84},
    '{3'd6, 32'h0000_1000, 32'h90,        32'h0,         16'hFFF0, 4'd1, 2'd1, 32'h90,        32'h0000_0FF0, 32'h94},
    '{3'd6, 32'h0001_0000, 32'h10,        32'h0,         16'h8000, 4'd0, 2'd1, 32'h10,        32'h0000_8000, 32'h14},
    '{3'd3, 32'h0,         32'h88,        32'h0,         16'h0,    4'd0, 2'd2, 32'h88,        32'hC0DE_0022, 32'h84},
    '{3'd7, 32'h0000_0555, 32'h77,        32'h12,        16'h0,    4'd0, 2'd0, 32'h0,         32'h0000_0555, 32'h77},
    '{3'd1, 32'hFFFF_FFFC, 32'h20,        32'hFC,        16'h0,    4'd0, 2'd1, 32'hFC,        32'h20,        32'hFC},
    '{3'd2, 32'h0000_0700, 32'h30,        32'hFFFF_FFFC, 16'h0,    4'd1, 2'd1, 32'hFFFF_FFFC, 32'h30,        32'h0},
    '{3'd3, 32'h0,         32'h0,         32'h0,         16'h0,    4'd0, 2'd2, 32'h0,         32'hC0DE_0000, 32'hFFFF_FFFC},
    '{3'd5, 32'h0,         32'hFC,        32'h0,         16'h0,    4'd0, 2'd2, 32'hFC,        32'h0000_0700, 32'hF8}
  };

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R6";
      3'd6: return "R7";
      3'd7: return "R11";
      default: return "R5";
    endcase
  endfunction

  // Drive one request on the 32-bit instance; returns cycles from acceptance to done.
  // With hold set, a competing request stays offered while the unit is busy (R8).
  task automatic run_op(input vec_t v, input bit hold, output int lat);
    @(negedge clk);
    cur_stall = int'(v.stall);
    acc_cnt   = 0;
    r_op = v.op; r_pc = v.pc; r_a = v.a; r_b = v.b; r_imm = v.imm;
    r_valid = 1'b1;
    @(negedge clk);
    lat = 1;
    if (hold) begin
      r_op = 3'd6; r_a = 32'hB0; r_pc = 32'h9990;
    end else begin
      r_valid = 1'b0;
    end
    while (!d_done && lat < 60) begin
      if (m_valid)
        check(m_addr == v.addr && m_we == (v.kind == 2'd1), "R8 stalled address held",
              {31'd0, m_we, m_addr}, {31'd0, (v.kind == 2'd1), v.addr});
      @(negedge clk);
      lat++;
    end
    r_valid = 1'b0;
  endtask

  initial begin : main
    int lat;
    repeat (3) @(negedge clk);
    check(r_ready && !d_done && !m_valid, "R1 idle during reset",
          {61'd0, r_ready, d_done, m_valid}, 64'h4);
    rst = 1'b0;
    @(negedge clk);
    check(r_ready && !d_done && !m_valid, "R1 idle after reset",
          {61'd0, r_ready, d_done, m_valid}, 64'h4);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = req_of(v.op);
      run_op(v, 1'b0, lat);
      check(d_pc == v.epc, {t, " next PC"}, d_pc, v.epc);
      check(d_ptr == v.eptr, {t, " pointer"}, d_ptr, v.eptr);
      if (v.kind == 2'd0)
        check(acc_cnt == 0, {t, " no memory access"}, acc_cnt, 0);
      else if (v.kind == 2'd1)
        check(acc_cnt == 1 && last_we && last_addr == v.addr && last_wdata == v.pc,
              {t, " PC written at pointer"}, {last_addr, last_wdata}, {v.addr, v.pc});
      else
        check(acc_cnt == 1 && !last_we && last_addr == v.addr,
              {t, " read at pointer"}, {31'd0, last_we, last_addr}, {32'd0, v.addr});
      check(lat == ((v.kind == 2'd0) ? 1 : 2 + int'(v.stall)), "R9 done latency",
            lat, (v.kind == 2'd0) ? 1 : 2 + int'(v.stall));
      @(negedge clk);
      check(!d_done, "R9 done single cycle", d_done, 0);
    end

    // R8: busy unit ignores a competing request
    begin
      vec_t v;
      v = '{3'd4, 32'h0000_0ABC, 32'hA0, 32'h0, 16'h0, 4'd4, 2'd1, 32'hA0, 32'h0ABC, 32'hA4};
      run_op(v, 1'b1, lat);
      check(lat == 6, "R8 latency under stall", lat, 6);
      @(negedge clk);
      check(!d_done && !m_valid && acc_cnt == 1 && d_ptr == 32'hA4,
            "R8 competing request not taken", {30'd0, d_done, m_valid, d_ptr}, {32'd0, 32'hA4});
    end

    // R1: reset during a pending access
    @(negedge clk);
    cur_stall = 10; acc_cnt = 0;
    r_op = 3'd4; r_a = 32'hC0; r_pc = 32'h1234; r_valid = 1'b1;
    @(negedge clk);
    r_valid = 1'b0;
    @(negedge clk);
    check(m_valid, "R8 request pending before reset", m_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!m_valid && r_ready && !d_done && acc_cnt == 0, "R1 reset abandons access",
          {60'd0, m_valid, r_ready, d_done, acc_cnt[0]}, 64'h4);
    @(negedge clk);
    check(!d_done && !m_valid, "R1 no late completion", {62'd0, d_done, m_valid}, 0);

    // R10: 64-bit build steps by 8 bytes
    @(negedge clk);
    w_cnt = 0;
    w_op = 3'd4; w_a = 64'h100; w_pc = 64'hFEDC_BA98_7654_3210; w_valid = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    @(negedge clk);
    check(w_done && w_ptr == 64'h108 && w_pcn == 64'hFEDC_BA98_7654_3210,
          "R10 wide push pointer step", w_ptr, 64'h108);
    check(w_cnt == 1 && w_lwe && w_laddr == 64'h100 && w_ldata == 64'hFEDC_BA98_7654_3210,
          "R10 wide push write", w_ldata, 64'hFEDC_BA98_7654_3210);
    @(negedge clk);
    w_cnt = 0;
    w_op = 3'd5; w_a = 64'h100; w_valid = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    @(negedge clk);
    check(w_done && w_ptr == 64'hF8, "R10 wide pop pointer step", w_ptr, 64'hF8);
    check(w_pcn == 64'h1234_5678_9ABC_DEF0 && w_cnt == 1 && !w_lwe && w_laddr == 64'h100,
          "R10 wide pop data", w_pcn, 64'h1234_5678_9ABC_DEF0);

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule